// File: doc/BRIEF.md
# Hebbian Ternary Synapse Weight

This block is a digital stand-in for an adaptive synapse. It keeps one resistance-like value as an unsigned fixed-point fraction, where 0 stands for 0.0 and the all-ones code stands for 1.0. A low value means a strong excitatory connection and a high value means a weak, inhibitory one. On each update strobe the block looks at the presynaptic and postsynaptic activity flags. Correlated firing moves the value one step down, which strengthens the connection. Presynaptic firing without a postsynaptic response moves it one step up, which weakens the connection. The value saturates at both ends of the scale.

The stored value is also read out as a balanced-ternary weight. The scale is split into three zones by two threshold parameters, and the weight is decoded combinationally from the registered value. A downstream reflex circuit can use the weight directly. The raw value is available as well, for finer use.

Top module: `hebb_trit_synapse`

## Requirements
- R1: While reset is asserted, and right after it is released, the state is 32768 (0.5) and the weight reads neutral (2'b00).
- R2: A state strictly below LO_TH (default 21627) reads as +1, encoded 2'b01.
- R3: A state strictly above HI_TH (default 43254) reads as -1, encoded 2'b10.
- R4: A state from LO_TH to HI_TH inclusive reads as 0, encoded 2'b00. The code 2'b11 never appears.
- R5: On a cycle with the strobe high and both pre and post high, the state falls by STEP (default 66) at the next clock edge.
- R6: On a cycle with the strobe high, pre high and post low, the state rises by STEP at the next clock edge.
- R7: With the strobe high and pre low, the state does not change, whatever post is.
- R8: With the strobe low, the state does not change, whatever pre and post are.
- R9: A decrease that would go below 0 leaves the state at 0.
- R10: An increase that would go above 65535 leaves the state at 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Update strobe; the state may change only when this is high |
| pre_act | input | 1 | Presynaptic activity flag |
| post_act | input | 1 | Postsynaptic activity flag |
| state_q | output | 16 | Registered state; 0 is 0.0 and 65535 is 1.0 |
| trit_o | output | 2 | Ternary weight: 01 = +1, 00 = 0, 10 = -1 |

## Verification
On every cycle the assertions check the one-step movements in both directions, the saturation at 0 and at 65535, the hold whenever the strobe or pre is low, and that the weight code stays inside its zone and is never 11. The directed scenarios are the only way to show the behaviour over a long run. They walk the state from the midpoint across each threshold, checking the last value on the neutral side and the first value past it. They then drive the state into both rails and keep pushing it there. They also confirm the exact reset value, which the assertions do not cover because those are disabled during reset.

// File: rtl/hebb_trit_synapse.sv
module hebb_trit_synapse #(
  parameter int W     = 16,
  parameter int STEP  = 66,
  parameter int LO_TH = 21627,
  parameter int HI_TH = 43254
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         pre_act,
  input  logic         post_act,
  output logic [W-1:0] state_q,
  output logic [1:0]   trit_o
);

  localparam logic [W-1:0] MID_V  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V  = {W{1'b1}};
  localparam logic [W-1:0] STEP_V = STEP[W-1:0];
  localparam logic [W-1:0] LO_V   = LO_TH[W-1:0];
  localparam logic [W-1:0] HI_V   = HI_TH[W-1:0];

  logic [W-1:0] dn_val, up_val;

  assign dn_val = (state_q < STEP_V) ? '0 : state_q - STEP_V;
  assign up_val = (state_q > MAX_V - STEP_V) ? MAX_V : state_q + STEP_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= MID_V;
    else if (upd_en && pre_act)
      state_q <= post_act ? dn_val : up_val;
  end

  assign trit_o = (state_q < LO_V) ? 2'b01 :
                  (state_q > HI_V) ? 2'b10 : 2'b00;

endmodule

// File: rtl/hebb_trit_synapse_chk.sv
module hebb_trit_synapse_chk #(
  parameter int W     = 16,
  parameter int STEP  = 66,
  parameter int LO_TH = 21627,
  parameter int HI_TH = 43254
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd_en,
  input logic         pre_act,
  input logic         post_act,
  input logic [W-1:0] state_q,
  input logic [1:0]   trit_o
);

  localparam logic [W-1:0] MAX_V  = {W{1'b1}};
  localparam logic [W-1:0] STEP_V = STEP[W-1:0];
  localparam logic [W-1:0] LO_V   = LO_TH[W-1:0];
  localparam logic [W-1:0] HI_V   = HI_TH[W-1:0];

  p_zone_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trit_o == 2'b01 |-> state_q < LO_V);

  p_zone_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trit_o == 2'b10 |-> state_q > HI_V);

  p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trit_o != 2'b11);

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && pre_act && post_act && state_q >= STEP_V)
      |=> state_q == $past(state_q) - STEP_V);

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && pre_act && !post_act && state_q <= MAX_V - STEP_V)
      |=> state_q == $past(state_q) + STEP_V);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !pre_act) |=> $stable(state_q));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(state_q));

  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && pre_act && post_act && state_q < STEP_V) |=> state_q == '0);

  p_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && pre_act && !post_act && state_q > MAX_V - STEP_V) |=> state_q == MAX_V);

endmodule

bind hebb_trit_synapse hebb_trit_synapse_chk #(
  .W(W), .STEP(STEP), .LO_TH(LO_TH), .HI_TH(HI_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .pre_act(pre_act),
  .post_act(post_act), .state_q(state_q), .trit_o(trit_o)
);

// File: tb/sim_hebb_trit_synapse.sv
module sim_hebb_trit_synapse;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic        pre_act = 1'b0;
  logic        post_act = 1'b0;
  logic [15:0] state_q;
  logic [1:0]  trit_o;

  int n_chk = 0;
  int n_bad = 0;
  int model = 32768;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hebb_trit_synapse u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .pre_act(pre_act),
    .post_act(post_act), .state_q(state_q), .trit_o(trit_o)
  );

  function automatic logic [1:0] want_trit(int s);
    if (s < 21627) return 2'b01;
    if (s > 43254) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_out(string stag, string ttag);
    check(stag, int'(state_q), model);
    check(ttag, int'(trit_o), int'(want_trit(model)));
  endtask

  task automatic apply(bit u, bit p, bit q, string stag, string ttag);
    upd_en = u; pre_act = p; post_act = q;
    if (u && p) begin
      if (q) model = (model < 66) ? 0 : model - 66;
      else   model = (model > 65535 - 66) ? 65535 : model + 66;
    end
    @(posedge clk);
    @(negedge clk);
    check_out(stag, ttag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_en = 1'b1; pre_act = 1'b1; post_act = 1'b0;
    @(posedge clk); @(negedge clk);
    model = 32768;
    check_out("R1 state in reset", "R1 trit in reset");
    upd_en = 1'b0; pre_act = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_out("R1 state after reset", "R1 trit after reset");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++)
      apply(1'b0, k[0], k[1], "R8 hold strobe low", "R8 trit");
  endtask

  task automatic t_pre_off();
    apply(1'b1, 1'b0, 1'b0, "R7 hold pre low post low", "R7 trit");
    apply(1'b1, 1'b0, 1'b1, "R7 hold pre low post high", "R7 trit");
  endtask

  task automatic t_strengthen();
    for (int k = 0; k < 168; k++)
      apply(1'b1, 1'b1, 1'b1, "R5 step down", "R4 trit neutral");
    check(" R4 last neutral value", int'(state_q), 21680);
    check(" R4 last neutral trit", int'(trit_o), 0);
    apply(1'b1, 1'b1, 1'b1, "R5 step down", "R2 trit");
    check(" R2 first excitatory value", int'(state_q), 21614);
    check(" R2 first excitatory trit", int'(trit_o), 1);
  endtask

  task automatic t_floor();
    while (model > 0)
      apply(1'b1, 1'b1, 1'b1, "R5 step down toward floor", "R2 trit");
    check(" R9 reached floor", int'(state_q), 0);
    apply(1'b1, 1'b1, 1'b1, "R9 held at floor", "R2 trit at floor");
    apply(1'b1, 1'b1, 1'b1, "R9 held at floor", "R2 trit at floor");
  endtask

  task automatic t_weaken();
    for (int k = 0; k < 158; k++)
      apply(1'b1, 1'b1, 1'b0, "R6 step up", "R4 trit neutral");
    check(" R4 last neutral value high side", int'(state_q), 43196);
    apply(1'b1, 1'b1, 1'b0, "R6 step up", "R3 trit");
    check(" R3 first inhibitory value", int'(state_q), 43262);
    check(" R3 first inhibitory trit", int'(trit_o), 2);
  endtask

  task automatic t_ceiling();
    while (model < 65535)
      apply(1'b1, 1'b1, 1'b0, "R6 step up toward ceiling", "R3 trit");
    check(" R10 reached ceiling", int'(state_q), 65535);
    apply(1'b1, 1'b1, 1'b0, "R10 held at ceiling", "R3 trit at ceiling");
    apply(1'b0, 1'b1, 1'b1, "R8 hold at ceiling", "R3 trit");
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 40; k++)
      apply(k % 5 != 0, k % 3 != 1, k % 2 == 0, "R5 R6 R7 R8 mixed", "R4 mixed trit");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_pre_off();
    t_strengthen();
    t_floor();
    t_reset();
    t_weaken();
    t_ceiling();
    t_reset();
    t_mixed();
    finish_run();
  end

  initial begin
    #(4 * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule